// File: doc/BRIEF.md
# Cavity Power and Quench Interlock

This block is a fast protection unit that sits beside the digital feedback loop of a superconducting RF cavity. On every sample strobe it evaluates three hazard rules. The first is a drive-power limit, which compares the squared magnitude of the drive I/Q pair against a host-programmed ceiling. The second is an open-loop quench rule, which compares reflected power against a programmable fraction of forward power. The third is a closed-loop quench rule, which compares the cavity amplitude against 80% of its set point.

Any rule that fires sets a sticky fault flag. While any flag is held, the drive-kill output cuts the incident drive. A drive-power fault also swaps the amplitude set point passed downstream for a fixed safe value. Only a host clear releases the flags. The closed-loop quench rule is silenced while the cavity is being pre-tuned.

Top module: `cav_guard`

## Requirements
- R1: After reset the flag vector `flt` is 0, `drive_kill` is 0, `sp_revert` is 0 and `amp_set_out` equals `amp_set`.
- R2: On a strobe where I*I + Q*Q >= `pwr_lim` (I, Q signed), flag bit 0 is set in the cycle after that strobe edge.
- R3: While flag bit 0 is held, `sp_revert` is 1 and `amp_set_out` equals the safe set point (parameter, default 50); otherwise `amp_set_out` equals `amp_set`.
- R4: With `loop_closed`=0, a strobe is a hit when `refl`*256 > `fwd`*`frac` (`frac` in 1/256 units). Flag bit 1 is set only on the 4th consecutive hit strobe. A non-hit strobe or a clear restarts the run, and cycles without a strobe neither count nor break the run.
- R5: With `loop_closed`=1 and `pretune`=0, a strobe where `amp`*5 < `amp_set`*4 sets flag bit 2.
- R6: With `loop_closed`=1 and `pretune`=1, the closed-loop quench rule never sets bit 2.
- R7: The open-loop rule has no effect when `loop_closed`=1, and the closed-loop rule has no effect when `loop_closed`=0.
- R8: `drive_kill` is 1 exactly while any flag bit is held, starting in the cycle after the triggering strobe.
- R9: Flags hold until `flt_clr`. If a clear and a new trip fall on the same edge, the tripping bit is set and the other bits are cleared.
- R10: Without `smp_vld`, no input pattern sets any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | Sample strobe; rules evaluate only when high |
| drv_i | input | 16 | Drive in-phase component, signed |
| drv_q | input | 16 | Drive quadrature component, signed |
| pwr_lim | input | 33 | Drive-power ceiling on I*I+Q*Q |
| fwd | input | 16 | Forward power |
| refl | input | 16 | Reflected power |
| frac | input | 8 | Reflected/forward trip ratio in 1/256 units |
| amp | input | 16 | Cavity voltage amplitude |
| amp_set | input | 16 | Amplitude set point |
| loop_closed | input | 1 | 1 = closed loop, 0 = open loop |
| pretune | input | 1 | Pre-tuning in progress |
| flt_clr | input | 1 | Host clear of all fault flags |
| drive_kill | output | 1 | Cut incident drive |
| sp_revert | output | 1 | Set point forced to safe value |
| amp_set_out | output | 16 | Set point passed to the loop |
| flt | output | 3 | Sticky flags: bit0 drive power, bit1 open-loop quench, bit2 closed-loop quench |

## Verification
The host clear and a fresh trip can land on the same clock edge, and the latch must then let the new fault win while dropping the older one. The bench provokes this as follows. It first latches a drive-power fault. It then strobes a closed-loop quench in the very cycle that `flt_clr` is high. It judges the result by requiring exactly bit 2 to be set, `drive_kill` to stay high and the set point to return from its safe value. The bench also sweeps drive I/Q over a grid, sweeps amplitude across the 80% boundary with pre-tuning on and off, and sweeps reflected power across the ratio threshold with run lengths of three and four.

// File: rtl/cav_guard_pkg.sv
// Package: shared fault indices and default widths for the cavity interlock.
// Assumes: flag positions are fixed; software decodes them by bit number.
package cav_guard_pkg;
    localparam int FLT_PWR = 0;   // drive-power fault bit
    localparam int FLT_OLQ = 1;   // open-loop quench bit
    localparam int FLT_CLQ = 2;   // closed-loop quench bit
    localparam int NFLT    = 3;   // number of fault bits
endpackage

// File: rtl/drv_pwr_mon.sv
// drv_pwr_mon: squares the signed drive I and Q, sums them and flags a trip on a
// strobe where the sum reaches the programmed limit.
// Assumes: inputs are stable during the strobe cycle; the result is combinational.
module drv_pwr_mon #(
    parameter int IQ_W = 16,
    localparam int PWR_W = 2*IQ_W + 1
) (
    input  logic                   smp_vld,
    input  logic signed [IQ_W-1:0] drv_i,
    input  logic signed [IQ_W-1:0] drv_q,
    input  logic [PWR_W-1:0]       pwr_lim,
    output logic                   pwr_trip
);
    logic signed [2*IQ_W-1:0] sq_i;
    logic signed [2*IQ_W-1:0] sq_q;
    logic [PWR_W-1:0]         pwr_sum;

    // Magnitude-squared of the drive vector, compared against the ceiling.
    always_comb begin
        sq_i     = drv_i * drv_i;
        sq_q     = drv_q * drv_q;
        pwr_sum  = {1'b0, sq_i} + {1'b0, sq_q};
        pwr_trip = smp_vld && (pwr_sum >= pwr_lim);
    end
endmodule

// File: rtl/quench_det.sv
// quench_det: applies the quench rule chosen by the loop mode.
//   open loop  : reflected power above a fraction of forward power for RUN_LEN
//                consecutive strobes.
//   closed loop: amplitude below 80% of set point (amp*5 < set*4), suppressed
//                while pre-tuning.
// Assumes: RUN_LEN >= 2; the run counter restarts on clear or in closed loop.
module quench_det #(
    parameter int PW_W    = 16,
    parameter int FRAC_W  = 8,
    parameter int AMP_W   = 16,
    parameter int RUN_LEN = 4,
    localparam int RUN_W  = $clog2(RUN_LEN),
    localparam int PROD_W = PW_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic              loop_closed,
    input  logic              pretune,
    input  logic              clr,
    input  logic [PW_W-1:0]   fwd,
    input  logic [PW_W-1:0]   refl,
    input  logic [FRAC_W-1:0] frac,
    input  logic [AMP_W-1:0]  amp,
    input  logic [AMP_W-1:0]  amp_set,
    output logic              ol_trip,
    output logic              cl_trip
);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);

    logic [PROD_W-1:0]  refl_sc;
    logic [PROD_W-1:0]  fwd_sc;
    logic               refl_hi;
    logic [AMP_W+2:0]   amp_x5;
    logic [AMP_W+2:0]   set_x4;
    logic               amp_low;
    logic [RUN_W-1:0]   run_cnt;

    // Scaled comparisons for both quench rules.
    always_comb begin
        refl_sc = {refl, {FRAC_W{1'b0}}};
        fwd_sc  = PROD_W'(fwd) * PROD_W'(frac);
        refl_hi = refl_sc > fwd_sc;
        amp_x5  = (AMP_W+3)'(amp) * (AMP_W+3)'(5);
        set_x4  = (AMP_W+3)'(amp_set) << 2;
        amp_low = amp_x5 < set_x4;
    end

    // Trip decisions for the current strobe.
    always_comb begin
        ol_trip = smp_vld && !loop_closed && refl_hi && (run_cnt == RUN_LAST);
        cl_trip = smp_vld && loop_closed && !pretune && amp_low;
    end

    // Counts consecutive open-loop hits, saturating at the trip position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (clr || loop_closed) begin
            run_cnt <= '0;
        end else if (smp_vld) begin
            if (!refl_hi)
                run_cnt <= '0;
            else if (run_cnt != RUN_LAST)
                run_cnt <= run_cnt + 1'b1;
        end
    end

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= RUN_LAST);                                            // R4
    AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !refl_hi && !loop_closed) |=> (run_cnt == '0));       // R4
endmodule

// File: rtl/fault_latch.sv
// fault_latch: one sticky flag per fault source. A trip sets its bit; a host
// clear drops all bits except those tripping on the same edge.
// Assumes: trip inputs are single-cycle qualified by the sample strobe.
module fault_latch #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] trip,
    input  logic         clr,
    output logic [N-1:0] flags
);
    for (genvar k = 0; k < N; k++) begin : g_flag
        // Sticky flag k: set wins over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[k] <= 1'b0;
            else if (trip[k])
                flags[k] <= 1'b1;
            else if (clr)
                flags[k] <= 1'b0;
        end
    end

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((flags & $past(flags)) == $past(flags)));              // R9
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (trip != '0) |=> ((flags & $past(trip)) == $past(trip)));        // R9
endmodule

// File: rtl/cav_guard.sv
// cav_guard: top of the cavity protection unit. Combines the drive-power monitor
// and the quench detector into sticky faults, drives the drive-kill and the
// set-point revert, and substitutes a safe set point after a power fault.
// Assumes: all inputs are synchronous to clk; flags clear only by flt_clr.
module cav_guard
    import cav_guard_pkg::*;
#(
    parameter int IQ_W    = 16,
    parameter int PW_W    = 16,
    parameter int FRAC_W  = 8,
    parameter int AMP_W   = 16,
    parameter int RUN_LEN = 4,
    parameter logic [AMP_W-1:0] SAFE_SP = 16'd50,
    localparam int PWR_W  = 2*IQ_W + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   smp_vld,
    input  logic signed [IQ_W-1:0] drv_i,
    input  logic signed [IQ_W-1:0] drv_q,
    input  logic [PWR_W-1:0]       pwr_lim,
    input  logic [PW_W-1:0]        fwd,
    input  logic [PW_W-1:0]        refl,
    input  logic [FRAC_W-1:0]      frac,
    input  logic [AMP_W-1:0]       amp,
    input  logic [AMP_W-1:0]       amp_set,
    input  logic                   loop_closed,
    input  logic                   pretune,
    input  logic                   flt_clr,
    output logic                   drive_kill,
    output logic                   sp_revert,
    output logic [AMP_W-1:0]       amp_set_out,
    output logic [NFLT-1:0]        flt
);
    logic            pwr_trip;
    logic            ol_trip;
    logic            cl_trip;
    logic [NFLT-1:0] trip_vec;

    drv_pwr_mon #(.IQ_W(IQ_W)) u_pwr (
        .smp_vld (smp_vld),
        .drv_i   (drv_i),
        .drv_q   (drv_q),
        .pwr_lim (pwr_lim),
        .pwr_trip(pwr_trip)
    );

    quench_det #(
        .PW_W(PW_W), .FRAC_W(FRAC_W), .AMP_W(AMP_W), .RUN_LEN(RUN_LEN)
    ) u_qd (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_vld    (smp_vld),
        .loop_closed(loop_closed),
        .pretune    (pretune),
        .clr        (flt_clr),
        .fwd        (fwd),
        .refl       (refl),
        .frac       (frac),
        .amp        (amp),
        .amp_set    (amp_set),
        .ol_trip    (ol_trip),
        .cl_trip    (cl_trip)
    );

    // Gather trip sources into the flag order.
    always_comb begin
        trip_vec          = '0;
        trip_vec[FLT_PWR] = pwr_trip;
        trip_vec[FLT_OLQ] = ol_trip;
        trip_vec[FLT_CLQ] = cl_trip;
    end

    fault_latch #(.N(NFLT)) u_lat (
        .clk  (clk),
        .rst_n(rst_n),
        .trip (trip_vec),
        .clr  (flt_clr),
        .flags(flt)
    );

    // Protective outputs derived from the held flags.
    always_comb begin
        drive_kill  = |flt;
        sp_revert   = flt[FLT_PWR];
        amp_set_out = sp_revert ? SAFE_SP : amp_set;
    end

    AST_CLQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flt[FLT_CLQ]) |-> $past(smp_vld && loop_closed && !pretune)); // R6
    AST_OLQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flt[FLT_OLQ]) |-> $past(smp_vld && !loop_closed));           // R7
    AST_PWR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flt[FLT_PWR]) |-> $past(smp_vld));                           // R10
    AST_SAFE_SP: assert property (@(posedge clk) disable iff (!rst_n)
        flt[FLT_PWR] |-> (amp_set_out == SAFE_SP && drive_kill));          // R3
endmodule

// File: tb/tb_cav_guard.sv
module tb_cav_guard;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               smp_vld = 1'b0;
    logic signed [15:0] drv_i = '0;
    logic signed [15:0] drv_q = '0;
    logic [32:0]        pwr_lim = 33'd30;
    logic [15:0]        fwd = 16'd400;
    logic [15:0]        refl = '0;
    logic [7:0]         frac = 8'd64;
    logic [15:0]        amp = 16'd100;
    logic [15:0]        amp_set = 16'd100;
    logic               loop_closed = 1'b0;
    logic               pretune = 1'b0;
    logic               flt_clr = 1'b0;
    logic               drive_kill;
    logic               sp_revert;
    logic [15:0]        amp_set_out;
    logic [2:0]         flt;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    cav_guard dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .drv_i(drv_i), .drv_q(drv_q),
        .pwr_lim(pwr_lim), .fwd(fwd), .refl(refl), .frac(frac), .amp(amp),
        .amp_set(amp_set), .loop_closed(loop_closed), .pretune(pretune),
        .flt_clr(flt_clr), .drive_kill(drive_kill), .sp_revert(sp_revert),
        .amp_set_out(amp_set_out), .flt(flt)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One strobe cycle; outputs are sampled at the following falling edge.
    task automatic pulse();
        @(negedge clk) smp_vld = 1'b1;
        @(negedge clk) smp_vld = 1'b0;
    endtask

    task automatic clear();
        @(negedge clk) flt_clr = 1'b1;
        @(negedge clk) flt_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 flt", int'(flt), 0);
        chk("R1 kill", int'(drive_kill), 0);
        chk("R1 revert", int'(sp_revert), 0);
        chk("R1 sp", int'(amp_set_out), 100);

        // R10: trip conditions without strobe
        drv_i = 16'sd6; drv_q = 16'sd6; loop_closed = 1'b1; amp = 16'd10;
        repeat (6) @(negedge clk);
        chk("R10 flt", int'(flt), 0);
        loop_closed = 1'b0; amp = 16'd100;

        // R2/R3/R8: drive-power sweep
        for (int i = -6; i <= 6; i++) begin
            for (int q = -6; q <= 6; q++) begin
                drv_i = 16'(i); drv_q = 16'(q);
                pulse();
                chk("R2 pwr", int'(flt[0]), (i*i + q*q >= 30) ? 1 : 0);
                chk("R3 sp", int'(amp_set_out), (i*i + q*q >= 30) ? 50 : 100);
                chk("R8 kill", int'(drive_kill), (i*i + q*q >= 30) ? 1 : 0);
                drv_i = '0; drv_q = '0;
                clear();
            end
        end
        chk("R3 revert off", int'(sp_revert), 0);

        // R5/R6/R7: closed-loop sweep around 80%
        loop_closed = 1'b1; refl = 16'd400;   // high refl must not matter (R7)
        for (int pt = 0; pt <= 1; pt++) begin
            for (int a = 70; a <= 90; a++) begin
                pretune = pt[0]; amp = 16'(a);
                pulse();
                chk(pt ? "R6 pretune" : "R5 clq", int'(flt),
                    (pt == 0 && a*5 < 400) ? 4 : 0);
                clear();
            end
        end
        pretune = 1'b0; amp = 16'd100; refl = '0;

        // R7: open loop ignores low amplitude
        loop_closed = 1'b0; amp = 16'd10;
        pulse();
        chk("R7 ol ignores amp", int'(flt), 0);
        amp = 16'd100;
        clear();

        // R4: run-length sweep across ratio threshold
        for (int r = 98; r <= 102; r++) begin
            refl = 16'(r);
            for (int n = 1; n <= 4; n++) begin
                pulse();
                chk("R4 run", int'(flt), (n == 4 && r*256 > 400*64) ? 2 : 0);
                repeat (n) @(negedge clk);   // idle gaps do not break the run
            end
            refl = '0;
            pulse();
            clear();
        end

        // R4: broken run
        refl = 16'd200;
        repeat (3) pulse();
        refl = '0; pulse();
        refl = 16'd200;
        repeat (3) pulse();
        chk("R4 broken run", int'(flt), 0);
        pulse();
        chk("R4 resumed run", int'(flt), 2);
        refl = '0; pulse();
        clear();

        // R9: sticky hold and same-edge clear/trip
        drv_i = 16'sd6; drv_q = 16'sd6;
        pulse();
        drv_i = '0; drv_q = '0;
        repeat (5) @(negedge clk);
        chk("R9 hold", int'(flt), 1);
        loop_closed = 1'b1; amp = 16'd70;
        @(negedge clk) begin smp_vld = 1'b1; flt_clr = 1'b1; end
        @(negedge clk) begin smp_vld = 1'b0; flt_clr = 1'b0; end
        chk("R9 same edge", int'(flt), 4);
        chk("R9 kill held", int'(drive_kill), 1);
        chk("R3 sp restored", int'(amp_set_out), 100);
        amp = 16'd100;
        clear();
        chk("R9 cleared", int'(flt), 0);
        chk("R8 kill off", int'(drive_kill), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule